// File: doc/BRIEF.md
# Push-Button Press Recorder with Hold-Off Re-Arm

This block turns a bouncing mechanical push-button into a clean press event. It runs on a fast system clock. The idle button level is high, and a press pulls it low. The raw level first passes through a two-stage synchronizer. After that, two independent mechanisms act on an armed flag. While the flag is high, a short shift register samples the button on the falling clock edge and watches for the first press edge. A hold-off counter, clocked on the rising edge, measures how long the button has stayed low without interruption. The first mechanism drops the flag, and the second raises it again.

The press is recorded when the flag returns high, and a one-clock pulse marks it. A downstream consumer can use the pulse as a single press event, or it can use the flag level as a "press in progress" indication. The block carries no data stream, so it has no valid/ready handshake. All pins are plain control levels or strobes. The hold-off length comes from the clock rate in kHz and the wanted delay in microseconds.

Top module: `button_debounce`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the following values: `btn_flag` = 1, `press_pulse` = 0, every shift-register bit = 1, hold-off counter = 0, and both synchronizer stages = 1 (idle level).
- R2: `btn_raw` reaches the shift register and the counter only through two rising-edge flip-flops. A level driven just after rising edge k is seen by the counter at edge k+3.
- R3: While `btn_flag` is high, each falling clock edge shifts the synchronized level into the most significant bit of a 4-bit register, and the older bits move one place toward bit 0. While `btn_flag` is low, the register holds its value.
- R4: When the register holds 4'b0011 (the two newest samples low, the two older ones high), `btn_flag` goes to 0 at the next rising edge, unless R6 applies.
- R5: The hold-off counter clears to 0 on any rising edge that sees the synchronized level high. Otherwise it increments, and it saturates at HOLD_MAX = CLK_KHZ*HOLD_US/1000 without wrapping.
- R6: `btn_flag` is set to 1 on the rising edge after the counter equals HOLD_MAX. Setting the flag takes priority over the 0011 clear.
- R7: `press_pulse` is high for exactly one clock cycle, namely the cycle after `btn_flag` rises from 0 to 1, and at no other time.
- R8: A press held low for any length of time yields exactly one pulse, and the flag stays high for the rest of the hold. Releasing the button without bounce yields no pulse.
- R9: If the last high level of a press (bounce included) is driven just after rising edge h, and the level stays low from then on, then `press_pulse` is high in the cycle after edge h+5+HOLD_MAX. A press that starts with at least two low cycles drops the flag four edges after it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw button level, idle high, low when pressed |
| btn_flag | output | 1 | Armed flag: low from the detected press edge until the hold-off completes |
| press_pulse | output | 1 | One-cycle strobe for each recorded press |

## Verification
All results are timed from the rising edge after which the bench changes `btn_raw`. On a clean press the flag falls after edge 4: two synchronizer stages and two falling-edge shifts, then the clearing edge. The pulse appears after edge HOLD_MAX+4, and after each bounce high the due edge moves to h+5+HOLD_MAX. The bench drives inputs one time unit after a rising edge. It samples three units later, before the falling edge, and compares the edge index at which each result is first seen against values worked out by hand for each stimulus row.

// File: rtl/debounce_pkg.sv
package debounce_pkg;
  // Width of the edge-watch shift register; the press pattern is built from it.
  localparam int unsigned EDGE_W = 4;

  // Newest samples sit in the upper half (low), older samples in the lower half (high).
  function automatic logic [EDGE_W-1:0] press_pattern();
    logic [EDGE_W-1:0] p;
    for (int i = 0; i < EDGE_W; i++) p[i] = (i < EDGE_W/2);
    return p;
  endfunction

  function automatic int unsigned hold_cycles(input int unsigned khz, input int unsigned us);
    return (khz * us) / 1000;
  endfunction
endpackage

// File: rtl/deb_sync2.sv
module deb_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/deb_edge_watch.sv
module deb_edge_watch
  import debounce_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              armed,
  input  logic              level,
  output logic [EDGE_W-1:0] window,
  output logic              edge_seen
);
  // Sampling on the falling edge keeps the window settled for the rising-edge flag logic.
  always_ff @(negedge clk) begin
    if (rst)        window <= '1;
    else if (armed) window <= {level, window[EDGE_W-1:1]};
  end

  assign edge_seen = (window == press_pattern());
endmodule

// File: rtl/deb_holdoff.sv
module deb_holdoff #(
  parameter int unsigned HOLD_MAX = 8,
  localparam int unsigned CNT_W = $clog2(HOLD_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             level,
  output logic [CNT_W-1:0] count,
  output logic             expired
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_MAX);

  always_ff @(posedge clk) begin
    if (rst || level)     count <= '0;
    else if (count != LIMIT) count <= count + CNT_W'(1);
  end

  assign expired = (count == LIMIT);
endmodule

// File: rtl/deb_strobe.sv
module deb_strobe (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  output logic strobe
);
  logic flag_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_d <= 1'b1;
      strobe <= 1'b0;
    end else begin
      flag_d <= flag;
      strobe <= flag && !flag_d;
    end
  end
endmodule

// File: rtl/button_debounce.sv
module button_debounce
  import debounce_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 50000,
  parameter int unsigned HOLD_US = 10,
  localparam int unsigned HOLD_MAX = hold_cycles(CLK_KHZ, HOLD_US),
  localparam int unsigned CNT_W = $clog2(HOLD_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_flag,
  output logic press_pulse
);
  logic              btn_sync;
  logic [EDGE_W-1:0] edge_win;
  logic              edge_hit;
  logic [CNT_W-1:0]  hold_cnt;
  logic              hold_done;
  logic              flag_q;

  deb_sync2 #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_in(btn_raw), .d_out(btn_sync)
  );

  deb_edge_watch u_edge (
    .clk(clk), .rst(rst), .armed(flag_q), .level(btn_sync),
    .window(edge_win), .edge_seen(edge_hit)
  );

  deb_holdoff #(.HOLD_MAX(HOLD_MAX)) u_hold (
    .clk(clk), .rst(rst), .level(btn_sync),
    .count(hold_cnt), .expired(hold_done)
  );

  // Re-arm outranks the edge clear.
  always_ff @(posedge clk) begin
    if (rst)            flag_q <= 1'b1;
    else if (hold_done) flag_q <= 1'b1;
    else if (edge_hit)  flag_q <= 1'b0;
  end

  deb_strobe u_strobe (
    .clk(clk), .rst(rst), .flag(flag_q), .strobe(press_pulse)
  );

  assign btn_flag = flag_q;
endmodule

// File: rtl/debounce_checker.sv
module debounce_checker
  import debounce_pkg::*;
#(
  parameter int unsigned HOLD_MAX = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              btn_sync,
  input logic [EDGE_W-1:0] edge_win,
  input logic [CNT_W-1:0]  hold_cnt,
  input logic              btn_flag,
  input logic              press_pulse
);
  p_frozen_window_r3: assert property (@(posedge clk) disable iff (rst)
    (!btn_flag && $past(!btn_flag)) |-> $stable(edge_win));

  p_fall_needs_pattern_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(btn_flag) |-> $past(edge_win == press_pattern()));

  p_high_clears_count_r5: assert property (@(posedge clk) disable iff (rst)
    $past(btn_sync) |-> (hold_cnt == '0));

  p_count_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= CNT_W'(HOLD_MAX));

  p_rise_needs_expiry_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(btn_flag) |-> $past(hold_cnt == CNT_W'(HOLD_MAX)));

  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (hold_cnt == CNT_W'(HOLD_MAX)) |=> btn_flag);

  p_pulse_follows_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(btn_flag) |=> press_pulse);

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> !press_pulse);

  p_pulse_with_flag_r7: assert property (@(posedge clk) disable iff (rst)
    press_pulse |-> btn_flag);
endmodule

bind button_debounce debounce_checker #(.HOLD_MAX(HOLD_MAX), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .btn_sync(btn_sync), .edge_win(edge_win),
  .hold_cnt(hold_cnt), .btn_flag(btn_flag), .press_pulse(press_pulse)
);

// File: tb/tb_button_debounce.sv
module tb_button_debounce;
  localparam int PERIOD = 10;
  localparam int HOLD   = 8;   // 1000 kHz * 8 us / 1000
  localparam int NVEC   = 5;
  localparam int WIN    = 60;

  // {bounce pattern (bit c = level after edge c, 1 = high), edge index of the pulse}
  localparam logic [23:0] VEC [NVEC] = '{
    {16'h0000, 8'd12},   // clean press
    {16'h0004, 8'd15},   // one bounce high at 2
    {16'h002C, 8'd18},   // bounces at 2,3,5
    {16'h0354, 8'd22},   // dense bounce, last high at 9
    {16'h0040, 8'd19}    // six lows then a late high at 6
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b1;
  logic btn_flag, press_pulse;
  int checks = 0;
  int failures = 0;

  always #(PERIOD/2) clk = ~clk;

  button_debounce #(.CLK_KHZ(1000), .HOLD_US(HOLD)) dut (
    .clk(clk), .rst(rst), .btn_raw(btn_raw),
    .btn_flag(btn_flag), .press_pulse(press_pulse)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Hold the button high for n edges; a bounce-free release must give no pulse.
  task automatic release_btn(input int n);
    int pulses = 0;
    for (int c = 0; c < n; c++) begin
      @(posedge clk); #1 btn_raw = 1'b1; #2;
      if (press_pulse) pulses++;
    end
    check("R8", "pulses on release", pulses, 0);
    check("R8", "flag after release", int'(btn_flag), 1);
  endtask

  // Drive a pattern then hold low; report first pulse edge and pulse count.
  task automatic press(input logic [15:0] pat, output int first, output int pulses,
                       output int flag_at6, output int flag_end);
    first = -1; pulses = 0; flag_at6 = -1; flag_end = -1;
    for (int c = 0; c < WIN; c++) begin
      @(posedge clk); #1 btn_raw = (c < 16) ? pat[c] : 1'b0; #2;
      if (press_pulse) begin
        pulses++;
        if (first < 0) first = c;
      end
      if (c == 6) flag_at6 = int'(btn_flag);
      if (c == WIN-1) flag_end = int'(btn_flag);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int first, pulses, f6, fend;
    // R1: reset values
    repeat (3) @(posedge clk);
    #3;
    check("R1", "flag in reset", int'(btn_flag), 1);
    check("R1", "pulse in reset", int'(press_pulse), 0);
    @(posedge clk); #1 rst = 1'b0;
    release_btn(10);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      press(VEC[v][23:8], first, pulses, f6, fend);
      check("R4", $sformatf("vec%0d flag dropped", v), f6, 0);
      check("R9", $sformatf("vec%0d pulse edge", v), first, int'(VEC[v][7:0]));
      check("R8", $sformatf("vec%0d pulse count", v), pulses, 1);
      check("R6", $sformatf("vec%0d flag re-armed", v), fend, 1);
      release_btn(20);
    end

    // R5 R9: short glitch drops the flag but never completes the hold-off
    begin
      int pulses_g = 0;
      int flag_g = -1;
      for (int c = 0; c < 40; c++) begin
        @(posedge clk); #1 btn_raw = (c < 2) ? 1'b0 : 1'b1; #2;
        if (press_pulse) pulses_g++;
        if (c == 6) flag_g = int'(btn_flag);
      end
      check("R4", "glitch drops flag", flag_g, 0);
      check("R5", "glitch gives no pulse", pulses_g, 0);
      check("R3", "flag stays low while frozen", int'(btn_flag), 0);
    end
    // Next clean press from the disarmed state still times from its own start
    press(16'h0000, first, pulses, f6, fend);
    check("R2", "press after glitch pulse edge", first, 4 + HOLD);
    check("R7", "press after glitch pulse count", pulses, 1);
    release_btn(20);

    // R1: reset in the middle of a press
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); #1 btn_raw = 1'b0;
    end
    #2 check("R4", "flag low before mid reset", int'(btn_flag), 0);
    @(posedge clk); #1 rst = 1'b1; btn_raw = 1'b1;
    @(posedge clk); @(posedge clk); #3;
    check("R1", "flag after mid reset", int'(btn_flag), 1);
    check("R1", "pulse after mid reset", int'(press_pulse), 0);
    #1 rst = 1'b0;
    release_btn(20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule